// File: doc/BRIEF.md
# DMA Bus Arbiter with Single and Block Transfer Modes

This block decides, on every clock, who owns one shared bus: the CPU or one of four DMA channels. Each channel holds a transfer count and a transfer mode. Software loads both before it uses the channel. A granted channel cycle stands for one byte or halfword transfer. The block only arbitrates and counts. It generates no addresses and moves no data.

A channel in single mode gives the bus back to the CPU after each transfer. A channel in block mode keeps the bus until its count runs out. In both modes the CPU gets at least one cycle before any DMA owner takes the bus again. A request that rises while a DMA transfer is running therefore waits for that CPU cycle, whatever its priority. When the bus is free, the lowest-numbered eligible channel wins. A channel that reaches terminal count pulses its terminal-count output and drops out of arbitration until it is loaded again.

The control is a three-state machine:
- `ST_CPU` is the CPU cycle. Transition `T_IDLE` stays in `ST_CPU` when no channel is eligible. `T_PICK_SINGLE` goes to `ST_SINGLE` when the winner is in single mode. `T_PICK_BLOCK` goes to `ST_BLOCK` when the winner is in block mode.
- `ST_SINGLE` is one transfer. Transition `T_SINGLE_DONE` always returns to `ST_CPU`.
- `ST_BLOCK` is a burst. Transition `T_BURST_MORE` stays in `ST_BLOCK` while transfers remain. Transition `T_BURST_END` returns to `ST_CPU` after the final transfer.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) gives the bus to the CPU and clears every channel count. After reset, a held request gets no grant until its channel is loaded again.
- R2: `grant` is one-hot on every cycle. Bit 0 is the CPU and bit i+1 is channel i. `owner` reads 4 for the CPU and i for channel i.
- R3: When no channel is eligible (request high and count non-zero), the CPU keeps the bus.
- R4: At the end of a CPU cycle, the lowest-numbered eligible channel gets the next cycle.
- R5: A single-mode channel makes one transfer and then yields one CPU cycle. While its request stays high and its count is non-zero, it repeats this pattern.
- R6: A block-mode channel is granted on consecutive cycles until its final transfer, whether or not its request stays high. The following cycle belongs to the CPU.
- R7: `cfg_load[i]` loads `cfg_count` into channel i and latches `cfg_block[i]` (1 = block mode, 0 = single mode). A loaded count of zero leaves the channel ineligible.
- R8: `tc[i]` is high for exactly one cycle, the cycle of channel i's final transfer. A count of N yields exactly N grants. At most one `tc` bit is high at a time.
- R9: After terminal count, a channel is not granted again until it is reloaded, even if its request stays high.
- R10: A CPU cycle separates any two DMA grants to different channels. A request that rises during a DMA transfer is served only after the following CPU cycle.
- R11: Requests are sampled at the rising edge that ends a CPU cycle. The grant appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Level-sensitive request, one bit per channel |
| cfg_load | input | 4 | Load strobe per channel for count and mode |
| cfg_block | input | 4 | Mode to latch per channel: 1 = block, 0 = single |
| cfg_count | input | 16 | Transfer count loaded into every strobed channel |
| grant | output | 5 | One-hot grant: bit 0 = CPU, bit i+1 = channel i |
| owner | output | 3 | Encoded owner: 0 to 3 = channel, 4 = CPU |
| tc | output | 4 | Terminal-count pulse per channel |

## Verification
The checker tests on every cycle:
- the grant is one-hot and `owner` agrees with it;
- an idle CPU cycle with no request is followed by another CPU cycle;
- a terminal-count pulse occurs only while its own channel is granted, and the CPU follows it;
- no channel hands the bus directly to another channel;
- a retired channel is not granted again without a reload.

Only the directed scenarios can show the rest:
- the priority order among competing channels;
- the exact spacing of single transfers;
- that a block burst ignores a dropped request;
- that a request rising during a transfer waits through the CPU cycle;
- that a count of N gives exactly N grants.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_CPU    = 2'd0,
        ST_SINGLE = 2'd1,
        ST_BLOCK  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dma_chan_counter.sv
// Per-channel transfer counter with latched mode.
module dma_chan_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_block,
    input  logic             xfer,
    output logic             armed,
    output logic             last,
    output logic             block_mode
);
    logic [CNT_W-1:0] cnt_q;
    logic             blk_q;

    // R7: a load overrides the decrement of the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            blk_q <= load_block;
        end else if (xfer && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        armed      = (cnt_q != '0);
        last       = (cnt_q == CNT_W'(1));
        block_mode = blk_q;
    end
endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority pick: the lowest set index wins.
module dma_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] cfg_load,
    input  logic [NUM_CH-1:0] cfg_block,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic [NUM_CH:0]   grant,
    output logic [$clog2(NUM_CH+1)-1:0] owner,
    output logic [NUM_CH-1:0] tc
);
    import dma_arb_pkg::*;

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int OWN_W = $clog2(NUM_CH + 1);

    arb_state_e        state_q, state_d;
    logic [IDX_W-1:0]  ch_q, ch_d;

    logic [NUM_CH-1:0] armed, last, blk, xfer, eligible;
    logic              win_found;
    logic [IDX_W-1:0]  win_idx;

    // One counter per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign xfer[g]     = (state_q != ST_CPU) && (ch_q == IDX_W'(g));
        assign eligible[g] = req[g] && armed[g];

        dma_chan_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .load       (cfg_load[g]),
            .load_val   (cfg_count),
            .load_block (cfg_block[g]),
            .xfer       (xfer[g]),
            .armed      (armed[g]),
            .last       (last[g]),
            .block_mode (blk[g])
        );
    end

    dma_prio_pick #(.N(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .cand  (eligible),
        .found (win_found),
        .idx   (win_idx)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        unique case (state_q)
            ST_CPU: begin
                if (win_found) begin                          // T_PICK_*
                    ch_d    = win_idx;
                    state_d = blk[win_idx] ? ST_BLOCK : ST_SINGLE;
                end                                           // else T_IDLE
            end
            ST_SINGLE: begin
                state_d = ST_CPU;                             // T_SINGLE_DONE
            end
            ST_BLOCK: begin
                if (armed[ch_q] && !last[ch_q]) begin
                    state_d = ST_BLOCK;                       // T_BURST_MORE
                end else begin
                    state_d = ST_CPU;                         // T_BURST_END
                end
            end
            default: state_d = ST_CPU;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CPU;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    // Outputs
    always_comb begin
        grant = '0;
        owner = OWN_W'(NUM_CH);
        tc    = '0;
        unique case (state_q)
            ST_CPU: begin
                grant[0] = 1'b1;
            end
            ST_SINGLE, ST_BLOCK: begin
                grant[int'(ch_q) + 1] = 1'b1;
                owner = OWN_W'(ch_q);
                tc    = xfer & last;
            end
            default: grant[0] = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int NUM_CH = 4,
    parameter int OWN_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] req,
    input logic [NUM_CH-1:0] cfg_load,
    input logic [NUM_CH:0]   grant,
    input logic [OWN_W-1:0]  owner,
    input logic [NUM_CH-1:0] tc
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(grant) == 1); // R2
    AST_OWNER_MATCH: assert property (@(posedge clk) disable iff (rst) grant[0] == (owner == OWN_W'(NUM_CH))); // R2
    AST_IDLE_KEEPS_CPU: assert property (@(posedge clk) disable iff (rst) (grant[0] && (req == '0)) |=> grant[0]); // R3
    AST_TC_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst) $countones(tc) <= 1); // R8

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_TC_WHILE_GRANTED: assert property (@(posedge clk) disable iff (rst) tc[g] |-> grant[g+1]); // R8
        AST_TC_THEN_CPU: assert property (@(posedge clk) disable iff (rst) tc[g] |=> grant[0]); // R6
        AST_NO_DIRECT_HANDOFF: assert property (@(posedge clk) disable iff (rst) grant[g+1] |=> (grant[0] || grant[g+1])); // R10
        AST_RETIRED_STAYS_OFF: assert property (@(posedge clk) disable iff (rst) (tc[g] && !cfg_load[g]) ##1 !cfg_load[g] |=> !grant[g+1]); // R9
    end
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NUM_CH(NUM_CH), .OWN_W(OWN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .cfg_load (cfg_load),
    .grant    (grant),
    .owner    (owner),
    .tc       (tc)
);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req = '0;
    logic [3:0]  cfg_load = '0;
    logic [3:0]  cfg_block = '0;
    logic [15:0] cfg_count = '0;
    logic [4:0]  grant;
    logic [2:0]  owner;
    logic [3:0]  tc;

    int checks = 0;
    int fails  = 0;

    localparam int CPU = 4;

    always #5 clk = ~clk;

    dma_bus_arbiter u_dut (
        .clk(clk), .rst(rst), .req(req), .cfg_load(cfg_load),
        .cfg_block(cfg_block), .cfg_count(cfg_count),
        .grant(grant), .owner(owner), .tc(tc)
    );

    // Advance one edge and compare owner, grant and tc
    task automatic step(input int exp_own, input logic [3:0] exp_tc, input string tag);
        logic [4:0] exp_grant;
        @(posedge clk); #1;
        exp_grant = (exp_own == CPU) ? 5'b00001 : (5'b00010 << exp_own);
        checks++;
        if (owner !== 3'(exp_own) || grant !== exp_grant || tc !== exp_tc) begin
            fails++;
            $display("FAIL %s: owner=%0d grant=%b tc=%b expected owner=%0d grant=%b tc=%b",
                     tag, owner, grant, tc, exp_own, exp_grant, exp_tc);
        end
    endtask

    task automatic load(input logic [3:0] mask, input logic [15:0] cnt, input logic [3:0] blk);
        cfg_load = mask; cfg_count = cnt; cfg_block = blk;
        step(CPU, 4'b0000, "R7 load cycle");
        cfg_load = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; cfg_load = '0;
        step(CPU, 4'b0000, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        req = 4'b0001;
        load(4'b0001, 16'd5, 4'b0000);
        step(0, 4'b0000, "R11 grant after sample");
        rst = 1'b1;
        step(CPU, 4'b0000, "R1 reset returns CPU");
        rst = 1'b0;
        step(CPU, 4'b0000, "R1 count cleared");
        step(CPU, 4'b0000, "R1 count cleared");
    endtask

    task automatic t_single();
        do_reset();
        req = 4'b0100;
        load(4'b0100, 16'd3, 4'b0000);
        step(2, 4'b0000, "R5 first transfer");
        step(CPU, 4'b0000, "R5 CPU between");
        step(2, 4'b0000, "R5 second transfer");
        step(CPU, 4'b0000, "R5 CPU between");
        step(2, 4'b0100, "R8 final transfer tc");
        step(CPU, 4'b0000, "R8 tc one cycle");
        step(CPU, 4'b0000, "R9 retired");
        step(CPU, 4'b0000, "R9 retired");
        req = 4'b0000;
        step(CPU, 4'b0000, "R3 idle");
    endtask

    task automatic t_priority();
        do_reset();
        req = 4'b1010;
        load(4'b1010, 16'd2, 4'b0000);
        step(1, 4'b0000, "R4 ch1 over ch3");
        step(CPU, 4'b0000, "R5 CPU between");
        step(1, 4'b0010, "R4 ch1 again");
        step(CPU, 4'b0000, "R10 CPU between owners");
        step(3, 4'b0000, "R4 ch3 after ch1 done");
        step(CPU, 4'b0000, "R5 CPU between");
        step(3, 4'b1000, "R8 ch3 tc");
        step(CPU, 4'b0000, "R9 both retired");
    endtask

    task automatic t_late();
        do_reset();
        load(4'b0001, 16'd1, 4'b0000);
        req = 4'b1000;
        load(4'b1000, 16'd2, 4'b0000);
        step(3, 4'b0000, "R11 ch3 granted");
        req = 4'b1001;
        step(CPU, 4'b0000, "R10 late request waits");
        step(0, 4'b0001, "R4 late higher priority");
        step(CPU, 4'b0000, "R10 CPU between");
        step(3, 4'b1000, "R5 ch3 resumes");
        step(CPU, 4'b0000, "R9 done");
    endtask

    task automatic t_block();
        do_reset();
        load(4'b0001, 16'd1, 4'b0000);
        req = 4'b0100;
        load(4'b0100, 16'd3, 4'b0100);
        step(2, 4'b0000, "R6 burst start");
        req = 4'b0001;
        step(2, 4'b0000, "R6 burst ignores req drop");
        step(2, 4'b0100, "R6 burst final tc");
        step(CPU, 4'b0000, "R6 release to CPU");
        step(0, 4'b0001, "R10 next owner after CPU");
        step(CPU, 4'b0000, "R5 CPU after single");
    endtask

    task automatic t_zero();
        do_reset();
        req = 4'b0010;
        load(4'b0010, 16'd0, 4'b0000);
        step(CPU, 4'b0000, "R7 zero count ineligible");
        step(CPU, 4'b0000, "R7 zero count ineligible");
        load(4'b0010, 16'd1, 4'b0010);
        step(1, 4'b0010, "R7 reload re-arms");
        step(CPU, 4'b0000, "R6 release after one");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1;
        step(CPU, 4'b0000, "R1 reset state");
        step(CPU, 4'b0000, "R2 reset grant");
        rst = 1'b0;
        t_reset();
        t_single();
        t_priority();
        t_late();
        t_block();
        t_zero();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule